// File: doc/BRIEF.md
# Token-Ring Bus Arbiter

This block shares one bus among a small set of clients (three by default, named A, B and C). Arbitration uses a single token. It travels around a closed ring of identical per-client controllers. Each controller has four states: idle, ready, busy and pass. A controller acts only while the token is with it.

When the token reaches a controller whose client is requesting, the controller spends one cycle in a ready step and then acknowledges the client. It keeps the acknowledge for as long as the request stays high. After the request drops, the controller hands the token to the next client in the fixed order A, B, C, A. A controller whose client is not requesting sends the token straight on.

Each hop between controllers goes through one register stage. The block reports which client holds the token and whether the bus is reserved, that is, in the ready step or granted.

Top module: `tok_ring_arb`

## Requirements
- R1: While reset (rst_n low) is applied and in the first cycle after it is released, every ack bit is 0, active is 0 and holder reads 0, meaning client A.
- R2: If the token is with a client that is requesting, the cycle after arrival is a ready cycle: active is 1 and ack is still 0. The acknowledge for that client starts in the following cycle.
- R3: The acknowledge of a client stays high while its request stays high. It goes low in the first cycle after the request is seen low, and holder still names that client in that cycle.
- R4: A token that arrives at a client that is not requesting stays with that client for exactly two cycles, then moves on. During those two cycles ack stays 0 and active stays 0.
- R5: The token moves in the order A, B, C, A. The holder codes are A=0, B=1, C=2, and 3 means no holder. While a client is acknowledged, holder names that client.
- R6: At most one ack bit is high in any cycle.
- R7: A client that drops its request and raises it again is not acknowledged again until every other waiting client has been served. It gets the token back only after the token has gone all the way round the ring.
- R8: A request that falls during the ready cycle still yields exactly one cycle of acknowledge. The token then moves on.
- R9: active is 1 exactly in ready cycles and in acknowledged cycles. It is 0 whenever no client is in the ready step or acknowledged.
- R10: After reset, holder never shows the no-holder code 3. Under random traffic where each client holds its request until it is acknowledged, every request is acknowledged within a bounded number of cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N_CLIENTS | Request from each client; bit 0 is A |
| ack | output | N_CLIENTS | Bus grant to each client; bit 0 is A |
| holder | output | HOLD_W | Index of the client holding the token; N_CLIENTS means none |
| active | output | 1 | Bus reserved: a client is in the ready step or acknowledged |

## Verification
The bench targets the cycle timing around the ready step. A design that granted on token arrival would raise ack one cycle early. A design that re-checked the request in the ready step would drop the one-cycle grant that a very short request should still get.

It also targets fairness when a client drops its request and raises it again at once. A controller that left the pass state on a fresh request instead of waiting for the token would take the bus away from a client further along the ring.

Idle circulation is timed hop by hop to catch a wrong ring order or a missing link register. A long run with random request lengths checks mutual exclusion and a bound on waiting time.

// File: rtl/arb_pkg.sv
package arb_pkg;

   typedef enum logic [1:0] {
      ND_IDLE  = 2'd0,
      ND_READY = 2'd1,
      ND_BUSY  = 2'd2,
      ND_PASS  = 2'd3
   } node_st_t;

   function automatic int unsigned ring_prev(input int unsigned idx, input int unsigned n);
      return (idx + n - 1) % n;
   endfunction

endpackage

// File: rtl/ring_node.sv
module ring_node
   import arb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tok_in,
   input  logic req,
   output logic ack,
   output logic pass,
   output logic claim,
   output logic engaged
);

   node_st_t st, nxt;

   always_comb begin
      nxt = st;
      unique case (st)
         ND_IDLE: begin
            if (tok_in && req)      nxt = ND_READY;
            else if (tok_in)        nxt = ND_PASS;
         end
         ND_READY:                  nxt = ND_BUSY;
         ND_BUSY: begin
            if (!req)               nxt = ND_PASS;
         end
         ND_PASS: begin
            if (tok_in && req)      nxt = ND_READY;
            else if (!tok_in)       nxt = ND_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ND_IDLE;
      else        st <= nxt;
   end

   assign ack     = (st == ND_BUSY);
   assign pass    = (st == ND_PASS);
   assign engaged = (st == ND_READY) || (st == ND_BUSY);
   assign claim   = tok_in || (st != ND_IDLE);

endmodule

// File: rtl/token_link.sv
module token_link #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pass_in,
   output logic tok_out
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tok_out <= RST_VAL;
      else        tok_out <= pass_in;
   end

endmodule

// File: rtl/holder_enc.sv
module holder_enc #(
   parameter int unsigned N_CLIENTS = 3,
   parameter int unsigned HOLD_W    = 2
) (
   input  logic [N_CLIENTS-1:0] claim,
   input  logic [N_CLIENTS-1:0] engaged,
   output logic [HOLD_W-1:0]    holder,
   output logic                 active
);

   localparam logic [HOLD_W-1:0] NONE_CODE = HOLD_W'(N_CLIENTS);

   always_comb begin
      holder = NONE_CODE;
      for (int i = N_CLIENTS - 1; i >= 0; i--) begin
         if (claim[i]) holder = HOLD_W'(i);
      end
   end

   assign active = |engaged;

endmodule

// File: rtl/tok_ring_arb.sv
module tok_ring_arb #(
   parameter  int unsigned N_CLIENTS = 3,
   localparam int unsigned HOLD_W    = $clog2(N_CLIENTS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_CLIENTS-1:0] req,
   output logic [N_CLIENTS-1:0] ack,
   output logic [HOLD_W-1:0]    holder,
   output logic                 active
);

   generate
      if (N_CLIENTS < 2) begin : g_bad_size
         $error("tok_ring_arb: N_CLIENTS must be at least 2");
      end
   endgenerate

   logic [N_CLIENTS-1:0] tok;
   logic [N_CLIENTS-1:0] pass;
   logic [N_CLIENTS-1:0] claim;
   logic [N_CLIENTS-1:0] engaged;

   for (genvar i = 0; i < N_CLIENTS; i++) begin : g_ring
      localparam int unsigned PREV = arb_pkg::ring_prev(i, N_CLIENTS);

      token_link #(.RST_VAL(i == 0)) u_link (
         .clk     (clk),
         .rst_n   (rst_n),
         .pass_in (pass[PREV]),
         .tok_out (tok[i])
      );

      ring_node u_node (
         .clk     (clk),
         .rst_n   (rst_n),
         .tok_in  (tok[i]),
         .req     (req[i]),
         .ack     (ack[i]),
         .pass    (pass[i]),
         .claim   (claim[i]),
         .engaged (engaged[i])
      );
   end

   holder_enc #(.N_CLIENTS(N_CLIENTS), .HOLD_W(HOLD_W)) u_enc (
      .claim   (claim),
      .engaged (engaged),
      .holder  (holder),
      .active  (active)
   );

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
   parameter int unsigned N_CLIENTS = 3,
   parameter int unsigned HOLD_W    = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [N_CLIENTS-1:0] req,
   input logic [N_CLIENTS-1:0] ack,
   input logic [HOLD_W-1:0]    holder,
   input logic                 active
);

   p_ack_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack));

   p_never_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
      holder != HOLD_W'(N_CLIENTS));

   p_ack_implies_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (ack == '0));

   for (genvar i = 0; i < N_CLIENTS; i++) begin : g_cli
      p_ready_before_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ack[i]) |-> ($past(active) && ($past(ack) == '0)));

      p_release_drops_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (ack[i] && !req[i]) |=> !ack[i]);

      p_holder_matches_r5: assert property (@(posedge clk) disable iff (!rst_n)
         ack[i] |-> (holder == HOLD_W'(i)));
   end

endmodule

bind tok_ring_arb arb_checker #(.N_CLIENTS(N_CLIENTS), .HOLD_W(HOLD_W)) u_arb_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .req    (req),
   .ack    (ack),
   .holder (holder),
   .active (active)
);

// File: tb/test_tok_ring_arb.sv
module test_tok_ring_arb;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 3;
   localparam int WAIT_BOUND = 60;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic [N-1:0] ack;
   logic [1:0]   holder;
   logic         active;

   int checks = 0;
   int errors = 0;

   tok_ring_arb #(.N_CLIENTS(N)) i_tok_ring_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req),
      .ack    (ack),
      .holder (holder),
      .active (active)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
      chk("R6 ack exclusive", ($countones(ack) <= 1) ? 1 : 0, 1);
   endtask

   task automatic do_reset(input logic [N-1:0] r);
      rst_n = 1'b0;
      req   = r;
      repeat (2) @(posedge clk);
      #1;
      rst_n = 1'b1;
      #1;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      req   = '0;
      repeat (2) @(posedge clk);
      #1;
      chk("R1 ack in reset", int'(ack), 0);
      chk("R1 holder in reset", int'(holder), 0);
      chk("R1 active in reset", int'(active), 0);
      rst_n = 1'b1;
      #1;
      chk("R1 holder after release", int'(holder), 0);
   endtask

   task automatic t_grant();
      do_reset(3'b001);
      step();
      chk("R2 ready cycle ack", int'(ack), 0);
      chk("R2 R9 ready cycle active", int'(active), 1);
      step();
      chk("R2 ack after ready", int'(ack), 1);
      chk("R9 active while acked", int'(active), 1);
      for (int k = 0; k < 3; k++) begin
         step();
         chk("R3 ack held", int'(ack), 1);
      end
      req = 3'b000;
      step();
      chk("R3 ack drops", int'(ack), 0);
      chk("R3 holder in pass", int'(holder), 0);
      chk("R9 active after release", int'(active), 0);
      step();
      chk("R5 token to B", int'(holder), 1);
   endtask

   task automatic t_idle_ring();
      int exp_h[6] = '{0, 1, 1, 2, 2, 0};
      do_reset(3'b000);
      for (int k = 0; k < 6; k++) begin
         step();
         chk("R4 R5 idle holder sequence", int'(holder), exp_h[k]);
         chk("R4 idle ack", int'(ack), 0);
         chk("R4 idle active", int'(active), 0);
      end
   endtask

   task automatic t_contend();
      do_reset(3'b101);
      step();
      step();
      chk("R6 A acked, C waits", int'(ack), 1);
      step();
      chk("R6 C still waits", int'(ack), 1);
      req = 3'b100;
      step();
      chk("R3 A released", int'(ack), 0);
      step();
      chk("R5 token at B", int'(holder), 1);
      step();
      chk("R4 B passes", int'(holder), 1);
      step();
      chk("R5 token at C", int'(holder), 2);
      step();
      chk("R2 C ready", int'(ack), 0);
      chk("R2 C ready active", int'(active), 1);
      step();
      chk("R2 C acked", int'(ack), 4);
      req = 3'b000;
      step();
   endtask

   task automatic t_reclaim();
      int first = 0;
      do_reset(3'b101);
      step();
      step();
      chk("R7 A acked first", int'(ack), 1);
      req = 3'b100;
      step();
      req = 3'b101;
      for (int k = 0; k < 20 && first == 0; k++) begin
         step();
         first = int'(ack);
      end
      chk("R7 C served before A again", first, 4);
      req = 3'b001;
      step();
      chk("R3 C released", int'(ack), 0);
      step();
      chk("R7 token back at A", int'(holder), 0);
      step();
      chk("R7 A ready", int'(ack), 0);
      step();
      chk("R7 A acked again", int'(ack), 1);
      req = 3'b000;
      step();
   endtask

   task automatic t_short();
      do_reset(3'b001);
      step();
      req = 3'b000;
      step();
      chk("R8 one-cycle ack", int'(ack), 1);
      step();
      chk("R8 ack gone", int'(ack), 0);
      chk("R8 holder in pass", int'(holder), 0);
      step();
      chk("R8 token moved", int'(holder), 1);
   endtask

   task automatic t_random();
      logic [15:0] lfsr = 16'hACE1;
      int phase[N];
      int waitc[N];
      int hold[N];
      int grants[N];
      int max_wait = 0;
      int none_seen = 0;
      do_reset(3'b000);
      for (int i = 0; i < N; i++) begin
         phase[i] = 0; waitc[i] = 0; hold[i] = 0; grants[i] = 0;
      end
      for (int c = 0; c < 3000; c++) begin
         step();
         if (holder == 2'd3) none_seen++;
         for (int i = 0; i < N; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (phase[i])
               0: if (lfsr[0] && lfsr[3]) begin
                     req[i] = 1'b1; phase[i] = 1; waitc[i] = 0;
                  end
               1: if (ack[i]) begin
                     grants[i]++;
                     hold[i]  = int'(lfsr[2:0]) % 6;
                     phase[i] = 2;
                     if (waitc[i] > max_wait) max_wait = waitc[i];
                  end else begin
                     waitc[i]++;
                  end
               default: if (hold[i] == 0) begin
                     req[i] = 1'b0; phase[i] = 0;
                  end else begin
                     hold[i]--;
                  end
            endcase
         end
      end
      chk("R10 bounded wait", (max_wait <= WAIT_BOUND) ? 1 : 0, 1);
      chk("R10 holder never none", none_seen, 0);
      for (int i = 0; i < N; i++)
         chk("R10 every client served", (grants[i] > 0) ? 1 : 0, 1);
      req = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_grant();
      t_idle_ring();
      t_contend();
      t_reclaim();
      t_short();
      t_random();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule